// File: doc/BRIEF.md
# Mixture-component match and coarse update

This block serves one pixel of a per-pixel background model built from a small mixture of colour distributions. Each distribution holds a mean for each of three 8-bit colour components, one spread value and a weight. The stored set arrives with the pixel, ordered from heaviest to lightest. The block tests the pixel against every distribution and picks the heaviest one that fits. It moves that distribution to the last output slot and updates it with fixed unit steps instead of learning-rate products. All other weights decay. When nothing fits, the lightest slot is overwritten with a fresh distribution centred on the pixel.

Alongside the updated set, the block outputs a foreground bit and a no-match flag. The foreground decision uses only the matched distribution's new weight. A later stage re-sorts the set and writes it back to the parameter store. This block only does the per-pixel arithmetic and the slot routing. It produces one result per cycle, one clock after its input.

Fields, least significant first. A pixel is three 8-bit components, with component k at bits [8k+7:8k]. Slot i of a parameter set occupies bits [46i+45:46i]. Inside a slot, component mean k is at [8k+7:8k], the spread is at [29:24] and the weight is at [45:30]. The spread is unsigned, has 2 fractional bits, and counts in quarters. Slot 0 is the heaviest input.

Top module: `mogu_match_update`

## Requirements
- R1: A slot fits the pixel when, for all three components, 8·|pixel − mean| ≤ 5·spread code. This is the pixel lying within 2.5 spreads of the mean.
- R2: When several slots fit, the one with the lowest index (highest weight) is the match. Lower-weight fits are treated as unmatched.
- R3: On a match at slot s, output slot N−1 holds the updated match. Output slots 0..N−2 hold the other inputs in their original relative order.
- R4: When no slot fits, out_nomatch is 1 and output slots 0..N−2 come from input slots 0..N−2. Output slot N−1 gets mean = pixel, spread code 48 (12.0) and weight 2048.
- R5: Each mean component of the match moves up by 1 when the pixel component is larger, down by 1 when it is smaller, and stays when they are equal.
- R6: The match's spread code rises by 1 (0.25) if any component has 4·|error| > spread code, and saturates at 63. Otherwise it falls by 1, but a code at or below 4 (1.0) is held.
- R7: The matched weight rises by 1024 and saturates at 65535. Every unmatched slot's weight falls by 512 and saturates at 0.
- R8: out_fg is 0 only when a match exists and its updated weight is greater than 16384. A pixel with no match is always foreground.
- R9: Results appear on the outputs one clock after in_valid is sampled high, and out_valid is then 1. A cycle with in_valid low gives out_valid 0 the next cycle and leaves out_dist, out_fg and out_nomatch unchanged.
- R10: While reset is active, out_valid, out_dist, out_fg and out_nomatch are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel and parameter set are valid this cycle |
| in_pix | input | 24 | Pixel, three 8-bit components |
| in_dist | input | 138 | Three stored distributions, slot 0 heaviest |
| out_valid | output | 1 | Output set valid |
| out_dist | output | 138 | Updated set, match or replacement in slot 2 |
| out_nomatch | output | 1 | No stored distribution fitted the pixel |
| out_fg | output | 1 | Foreground bit |

## Verification
All four outputs come from one register bank. Each result is therefore due exactly one rising edge after the cycle in which in_valid was high, with no further delay through the fit test, routing or update. The bench changes inputs on falling edges and reads results on the next falling edge. This lets it stream vectors back to back, checking vector i while vector i+1 is applied, so a result that lands one cycle late or early shows up as a mismatch. A final cycle with in_valid low and changed inputs confirms that the held result is still on the outputs one edge later.

// File: rtl/mogu_pkg.sv
package mogu_pkg;
  localparam int MW        = 8;
  localparam int SW        = 6;
  localparam int WW        = 16;
  localparam int NCH       = 3;
  localparam int FRAC      = 2;
  localparam int SPR_FLOOR = 1 << FRAC;
  localparam int SPR_MAX   = (1 << SW) - 1;

  typedef logic [NCH-1:0][MW-1:0] pix_t;
  typedef struct packed {
    logic [WW-1:0] wt;
    logic [SW-1:0] spr;
    pix_t          mu;
  } dist_t;
  localparam int DW = $bits(dist_t);

  function automatic int adiff(logic [MW-1:0] a, logic [MW-1:0] b);
    return (a > b) ? int'(a) - int'(b) : int'(b) - int'(a);
  endfunction

  // 2.5 spreads with spread in quarters: |d| <= 5*spr/8
  function automatic logic in_band(pix_t px, dist_t d);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < NCH; k++)
      if (adiff(px[k], d.mu[k]) * 8 > int'(d.spr) * 5) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [MW-1:0] mu_step(logic [MW-1:0] p, logic [MW-1:0] m);
    if (p > m) return m + 1'b1;
    if (p < m) return m - 1'b1;
    return m;
  endfunction

  function automatic logic [SW-1:0] spr_step(pix_t px, dist_t d);
    logic grow;
    grow = 1'b0;
    for (int k = 0; k < NCH; k++)
      if (adiff(px[k], d.mu[k]) * 4 > int'(d.spr)) grow = 1'b1;
    if (grow) return (int'(d.spr) == SPR_MAX) ? d.spr : d.spr + 1'b1;
    return (int'(d.spr) > SPR_FLOOR) ? d.spr - 1'b1 : d.spr;
  endfunction

  function automatic logic [WW-1:0] wt_up(logic [WW-1:0] w, logic [WW-1:0] inc);
    logic [WW:0] s;
    s = {1'b0, w} + {1'b0, inc};
    return s[WW] ? {WW{1'b1}} : s[WW-1:0];
  endfunction

  function automatic logic [WW-1:0] wt_dn(logic [WW-1:0] w, logic [WW-1:0] dec);
    return (w < dec) ? '0 : w - dec;
  endfunction

  function automatic logic near1(logic [MW-1:0] a, logic [MW-1:0] b);
    return adiff(a, b) <= 1;
  endfunction
endpackage

// File: rtl/mogu_cell.sv
module mogu_cell
  import mogu_pkg::*;
(
  input  pix_t  px,
  input  dist_t d,
  output logic  hit
);
  assign hit = in_band(px, d);
endmodule

// File: rtl/mogu_pick.sv
module mogu_pick #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic [N-1:0]  hit,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mogu_route.sv
module mogu_route
  import mogu_pkg::*;
#(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  dist_t [N-1:0] din,
  input  logic          any,
  input  logic [IW-1:0] idx,
  output dist_t [N-1:0] dout
);
  for (genvar j = 0; j < N - 1; j++) begin : g_keep
    assign dout[j] = (any && (j >= int'(idx))) ? din[j+1] : din[j];
  end
  assign dout[N-1] = any ? din[idx] : din[N-1];
endmodule

// File: rtl/mogu_update.sv
module mogu_update
  import mogu_pkg::*;
#(
  parameter int N        = 3,
  parameter int W_INC    = 1024,
  parameter int W_DEC    = 512,
  parameter int W_INIT   = 2048,
  parameter int SPR_INIT = 48,
  parameter int FG_TH    = 16384
) (
  input  pix_t          px,
  input  logic          any,
  input  dist_t [N-1:0] rin,
  output dist_t [N-1:0] nxt,
  output logic          fg
);
  dist_t bot;

  for (genvar j = 0; j < N - 1; j++) begin : g_decay
    assign nxt[j] = {wt_dn(rin[j].wt, WW'(W_DEC)), rin[j].spr, rin[j].mu};
  end

  always_comb begin
    bot = rin[N-1];
    if (any) begin
      for (int k = 0; k < NCH; k++) bot.mu[k] = mu_step(px[k], rin[N-1].mu[k]);
      bot.spr = spr_step(px, rin[N-1]);
      bot.wt  = wt_up(rin[N-1].wt, WW'(W_INC));
    end else begin
      bot.mu  = px;
      bot.spr = SW'(SPR_INIT);
      bot.wt  = WW'(W_INIT);
    end
  end

  assign nxt[N-1] = bot;
  assign fg       = !any || (bot.wt <= WW'(FG_TH));
endmodule

// File: rtl/mogu_match_update.sv
module mogu_match_update
  import mogu_pkg::*;
#(
  parameter int NSLOT    = 3,
  parameter int W_INC    = 1024,
  parameter int W_DEC    = 512,
  parameter int W_INIT   = 2048,
  parameter int SPR_INIT = 48,
  parameter int FG_TH    = 16384,
  localparam int IW      = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int PXW     = NCH * MW,
  localparam int SETW    = NSLOT * DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [PXW-1:0]  in_pix,
  input  logic [SETW-1:0] in_dist,
  output logic            out_valid,
  output logic [SETW-1:0] out_dist,
  output logic            out_nomatch,
  output logic            out_fg
);
  pix_t              px;
  dist_t [NSLOT-1:0] dset, routed, nxt, oset;
  logic [NSLOT-1:0]  ev_hits;
  logic              ev_any, fg_n;
  logic [IW-1:0]     ev_sel;
  dist_t             ev_sel_dist, obot;

  assign px   = in_pix;
  assign dset = in_dist;

  for (genvar i = 0; i < NSLOT; i++) begin : g_cell
    mogu_cell u_cell (.px(px), .d(dset[i]), .hit(ev_hits[i]));
  end

  mogu_pick #(.N(NSLOT), .IW(IW)) u_pick (.hit(ev_hits), .any(ev_any), .idx(ev_sel));

  mogu_route #(.N(NSLOT), .IW(IW)) u_route (
    .din(dset), .any(ev_any), .idx(ev_sel), .dout(routed));

  assign ev_sel_dist = routed[NSLOT-1];

  mogu_update #(.N(NSLOT), .W_INC(W_INC), .W_DEC(W_DEC), .W_INIT(W_INIT),
                .SPR_INIT(SPR_INIT), .FG_TH(FG_TH)) u_upd (
    .px(px), .any(ev_any), .rin(routed), .nxt(nxt), .fg(fg_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_dist    <= '0;
      out_nomatch <= 1'b0;
      out_fg      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_dist    <= nxt;
        out_nomatch <= !ev_any;
        out_fg      <= fg_n;
      end
    end
  end

  assign oset = out_dist;
  assign obot = oset[NSLOT-1];

  // R2
  first_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_any |-> ev_hits[ev_sel] && ((ev_hits & ((NSLOT'(1) << ev_sel) - NSLOT'(1))) == '0));

  // R3
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_nomatch && ($past(ev_sel) == '0) |->
      oset[0].mu == $past(dset[1].mu) && oset[0].spr == $past(dset[1].spr));

  // R4
  replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_nomatch |->
      obot.mu == $past(px) && obot.spr == SW'(SPR_INIT) && obot.wt == WW'(W_INIT));

  // R5
  for (genvar k = 0; k < NCH; k++) begin : g_mchk
    mean_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_nomatch |-> near1(obot.mu[k], $past(ev_sel_dist.mu[k])));
  end

  // R6
  spread_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_nomatch |->
      adiff(MW'(obot.spr), MW'($past(ev_sel_dist.spr))) <= 1 && int'(obot.spr) >= 1);

  // R8
  nomatch_fg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_nomatch |-> out_fg);

  // R9
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_dist) && $stable(out_fg));
endmodule

// File: tb/sim_mogu_match_update.sv
module sim_mogu_match_update;
  localparam int VW = 24 + 138 + 3;
  localparam int NV = 10;

  // {pixel c2,c1,c0 | slot2 | slot1 | slot0 | expected match index (3 = none) | expected fg}
  localparam logic [VW-1:0] TBL [NV] = '{
    {8'd100, 8'd100, 8'd100,
     16'd1000, 6'd4, 8'd0, 8'd0, 8'd0,  16'd30000, 6'd8, 8'd0, 8'd0, 8'd0,
     16'd40000, 6'd16, 8'd100, 8'd100, 8'd100, 2'd0, 1'b0},
    {8'd100, 8'd100, 8'd110,
     16'd1000, 6'd4, 8'd0, 8'd0, 8'd0,  16'd30000, 6'd8, 8'd0, 8'd0, 8'd0,
     16'd40000, 6'd16, 8'd100, 8'd100, 8'd100, 2'd0, 1'b0},
    {8'd100, 8'd100, 8'd111,
     16'd1000, 6'd4, 8'd0, 8'd0, 8'd0,  16'd30000, 6'd40, 8'd100, 8'd100, 8'd111,
     16'd40000, 6'd16, 8'd100, 8'd100, 8'd100, 2'd1, 1'b0},
    {8'd50, 8'd50, 8'd50,
     16'd5000, 6'd63, 8'd50, 8'd50, 8'd50,  16'd10000, 6'd63, 8'd50, 8'd50, 8'd50,
     16'd20000, 6'd8, 8'd48, 8'd50, 8'd52, 2'd0, 1'b0},
    {8'd30, 8'd10, 8'd200,
     16'd100, 6'd4, 8'd0, 8'd0, 8'd0,  16'd200, 6'd4, 8'd0, 8'd0, 8'd0,
     16'd300, 6'd4, 8'd0, 8'd0, 8'd0, 2'd3, 1'b1},
    {8'd255, 8'd255, 8'd255,
     16'd15360, 6'd4, 8'd255, 8'd255, 8'd255,  16'd50000, 6'd4, 8'd0, 8'd0, 8'd0,
     16'd60000, 6'd4, 8'd0, 8'd0, 8'd0, 2'd2, 1'b1},
    {8'd0, 8'd0, 8'd0,
     16'd50, 6'd4, 8'd200, 8'd200, 8'd200,  16'd100, 6'd4, 8'd200, 8'd200, 8'd200,
     16'd65000, 6'd63, 8'd0, 8'd0, 8'd30, 2'd0, 1'b0},
    {8'd128, 8'd128, 8'd128,
     16'd300, 6'd4, 8'd9, 8'd9, 8'd9,  16'd20000, 6'd20, 8'd128, 8'd128, 8'd128,
     16'd511, 6'd4, 8'd0, 8'd0, 8'd0, 2'd1, 1'b0},
    {8'd10, 8'd10, 8'd10,
     16'd900, 6'd4, 8'd200, 8'd200, 8'd200,  16'd1000, 6'd4, 8'd200, 8'd200, 8'd200,
     16'd15361, 6'd8, 8'd10, 8'd10, 8'd10, 2'd0, 1'b0},
    {8'd10, 8'd10, 8'd10,
     16'd900, 6'd4, 8'd200, 8'd200, 8'd200,  16'd1000, 6'd4, 8'd200, 8'd200, 8'd200,
     16'd15360, 6'd8, 8'd10, 8'd10, 8'd10, 2'd0, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [23:0]  in_pix = '0;
  logic [137:0] in_dist = '0;
  logic         out_valid, out_nomatch, out_fg;
  logic [137:0] out_dist;
  int nchk = 0, nbad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mogu_match_update #(.NSLOT(3), .W_INC(1024), .W_DEC(512), .W_INIT(2048),
                      .SPR_INIT(48), .FG_TH(16384)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix), .in_dist(in_dist),
    .out_valid(out_valid), .out_dist(out_dist), .out_nomatch(out_nomatch), .out_fg(out_fg));

  task automatic chk(input bit ok, input string tag, input logic [137:0] act, input logic [137:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Independent reference: real-valued fit test, list-based reordering.
  function automatic void model(input logic [23:0] px, input logic [137:0] ds,
                                output logic [137:0] o, output int sel);
    int pos, w, sp, base, mv, p;
    bit grow;
    logic [23:0] mm;
    sel = -1;
    for (int s = 0; s < 3; s++) begin
      bit ok = 1'b1;
      for (int c = 0; c < 3; c++) begin
        real lim = 2.5 * real'(int'(ds[s*46+24 +: 6])) / 4.0;
        real d = real'(int'(px[8*c +: 8])) - real'(int'(ds[s*46+8*c +: 8]));
        if (d < 0.0) d = -d;
        if (d > lim) ok = 1'b0;
      end
      if (ok && sel < 0) sel = s;
    end
    o = '0;
    pos = 0;
    for (int s = 0; s < 3; s++) begin
      if (s != sel && pos < 2) begin
        w = int'(ds[s*46+30 +: 16]);
        w = (w > 512) ? w - 512 : 0;
        o[pos*46 +: 46] = {16'(w), ds[s*46 +: 30]};
        pos++;
      end
    end
    if (sel < 0) begin
      o[92 +: 46] = {16'd2048, 6'd48, px};
    end else begin
      base = sel * 46;
      sp = int'(ds[base+24 +: 6]);
      grow = 1'b0;
      for (int c = 0; c < 3; c++) begin
        mv = int'(ds[base+8*c +: 8]);
        p  = int'(px[8*c +: 8]);
        if ((p - mv) * 4 > sp || (mv - p) * 4 > sp) grow = 1'b1;
        if (p > mv) mv = mv + 1;
        else if (p < mv) mv = mv - 1;
        mm[8*c +: 8] = 8'(mv);
      end
      if (grow) sp = (sp < 63) ? sp + 1 : 63;
      else if (sp > 4) sp = sp - 1;
      w = int'(ds[base+30 +: 16]) + 1024;
      if (w > 65535) w = 65535;
      o[92 +: 46] = {16'(w), 6'(sp), mm};
    end
  endfunction

  task automatic check_vec(input int i, output logic [137:0] exp_o);
    int msel;
    int tsel;
    model(TBL[i][164:141], TBL[i][140:3], exp_o, msel);
    tsel = (msel < 0) ? 3 : msel;
    chk(tsel == int'(TBL[i][2:1]), $sformatf("R1 R2 v%0d match index", i), 138'(tsel), 138'(TBL[i][2:1]));
    chk(out_valid === 1'b1, $sformatf("R9 v%0d out_valid", i), 138'(out_valid), 138'd1);
    chk(out_nomatch === (TBL[i][2:1] == 2'd3), $sformatf("R4 v%0d nomatch", i),
        138'(out_nomatch), 138'(TBL[i][2:1] == 2'd3));
    chk(out_fg === TBL[i][0], $sformatf("R8 v%0d fg", i), 138'(out_fg), 138'(TBL[i][0]));
    chk(out_dist === exp_o, $sformatf("R3 R5 R6 R7 v%0d set", i), out_dist, exp_o);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [137:0] last;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(out_valid === 1'b0 && out_fg === 1'b0 && out_nomatch === 1'b0, "R10 reset flags",
        {135'd0, out_valid, out_fg, out_nomatch}, 138'd0);
    chk(out_dist === '0, "R10 reset set", out_dist, 138'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Back-to-back stream: vector i checked while i+1 is applied.
    for (int i = 0; i <= NV; i++) begin
      if (i > 0) check_vec(i - 1, last);
      if (i < NV) begin
        in_valid = 1'b1;
        in_pix   = TBL[i][164:141];
        in_dist  = TBL[i][140:3];
      end else begin
        // R9: idle cycle with changed inputs must not disturb held results
        in_valid = 1'b0;
        in_pix   = 24'hABCDEF;
        in_dist  = {138{1'b1}};
      end
      @(negedge clk);
    end
    chk(out_valid === 1'b0, "R9 idle out_valid", 138'(out_valid), 138'd0);
    chk(out_dist === last, "R9 idle hold set", out_dist, last);
    chk(out_fg === TBL[NV-1][0], "R9 idle hold fg", 138'(out_fg), 138'(TBL[NV-1][0]));

    done = 1'b1;
    summary();
    $finish;
  end
endmodule